// File: doc/BRIEF.md
# Conversion Result Register Bank with Coherent Byte Reads

This block holds the latest result of an analog-to-digital converter for each of four input channels and makes those results readable by a processor whose data bus is only one byte wide. The converter side writes a 10-bit result into the register of a chosen channel. Each channel register is 16 bits wide and left-justified: the result occupies the top ten bits and the bottom six bits are always zero.

A 16-bit value read as two bytes can come apart if the converter updates it between the two reads. A single shared holding byte prevents this. When software reads the high byte of a channel, the block captures that channel's low byte into the holding byte at the same clock edge. A later low-byte read returns the captured byte instead of the live register. A word read returns all 16 bits at once and also refreshes the holding byte.

A stop input places the block in a frozen mode. A small two-state machine tracks this mode. In `ST_RUN` the block behaves normally. `ST_STOP` is entered at any clock edge where `stop_i` is high (transition RUN_TO_STOP). The machine returns to `ST_RUN` at any edge where `stop_i` is low (transition STOP_TO_RUN). While in `ST_STOP`, converter writes are dropped, reads return zero and the holding byte is left unchanged. The stored results are kept.

Top module: `adcres_regs`

## Requirements
- R1: A converter write (`cnv_we_i` high) stores `cnv_res_i` in the register of channel `cnv_ch_i` at the clock edge; the register then reads as `{cnv_res_i, 6'b0}`, and registers of the other channels keep their values.
- R2: Bits 5 to 0 of every result register read as zero in a word read.
- R3: A byte read with `rd_addr_i[0]` = 0 (high byte; channel in `rd_addr_i[2:1]`) returns bits 15 to 8 of that channel's register on `rd_data_o[7:0]`, with `rd_data_o[15:8]` zero, in the same cycle.
- R4: A high-byte read loads bits 7 to 0 of the addressed register into the shared holding byte at the clock edge. A byte read with `rd_addr_i[0]` = 1 (low byte) returns the holding byte on `rd_data_o[7:0]`, whatever channel the address names.
- R5: A converter write to a channel between its high-byte read and its low-byte read does not change the value that the low-byte read returns.
- R6: A word read (`rd_word_i` high) returns the full 16-bit register of channel `rd_addr_i[2:1]` in the same cycle (`rd_addr_i[0]` ignored) and loads its low byte into the holding byte.
- R7: One edge after `stop_i` goes high, reads return zero, converter writes are ignored and the holding byte does not load. One edge after `stop_i` goes low, reads return the contents kept from before the stop.
- R8: Reset clears all four result registers and the holding byte to zero.
- R9: When a converter write and a high-byte read of the same channel fall in the same cycle, the read returns the old high byte and the holding byte captures the old low byte. The new value is visible from the next cycle.
- R10: A low-byte read that no high-byte read preceded returns whatever the holding byte last captured.
- R11: While `rd_en_i` is low, `rd_data_o` is zero and the holding byte is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_i | input | 1 | Stop request; sampled into the mode machine |
| cnv_we_i | input | 1 | Converter result write strobe |
| cnv_ch_i | input | 2 | Channel written by the converter |
| cnv_res_i | input | 10 | 10-bit conversion result |
| rd_en_i | input | 1 | CPU read strobe |
| rd_word_i | input | 1 | Read all 16 bits instead of one byte |
| rd_addr_i | input | 3 | Byte address: [2:1] channel, [0] 0 = high byte, 1 = low byte |
| rd_data_o | output | 16 | Read data; byte reads use bits 7:0 |

## Verification
The two functions that can coincide are a converter write and a CPU high-byte read of the same channel. The bench provokes this directly with a single cycle that does both, and it also provokes it many times through random traffic that favours writes and reads to the same channels. A collision is judged correct when the read returns the old high byte. The low-byte read that follows must return the old low byte, and the next high-byte read must show the new value. Bench functions predict all three values from a register-level model.

// File: rtl/adcres_pkg.sv
package adcres_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_STOP = 1'b1
    } adcres_mode_e;
endpackage

// File: rtl/adcres_mode_fsm.sv
module adcres_mode_fsm
    import adcres_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req_i,
    output logic stopped_o
);
    adcres_mode_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  state_d = stop_req_i ? ST_STOP : ST_RUN;   // RUN_TO_STOP
            ST_STOP: state_d = stop_req_i ? ST_STOP : ST_RUN;   // STOP_TO_RUN
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  stopped_o = 1'b0;
            ST_STOP: stopped_o = 1'b1;
        endcase
    end

    p_enter_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req_i |=> stopped_o);
    p_leave_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_req_i |=> !stopped_o);
endmodule

// File: rtl/adcres_bank.sv
module adcres_bank #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned RES_W  = 10,
    parameter int unsigned REG_W  = 16,
    localparam int unsigned CH_W  = $clog2(NUM_CH),
    localparam int unsigned PAD_W = REG_W - RES_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stopped_i,
    input  logic             wr_en_i,
    input  logic [CH_W-1:0]  wr_ch_i,
    input  logic [RES_W-1:0] wr_res_i,
    output logic [REG_W-1:0] regs_o [NUM_CH]
);
    logic [RES_W-1:0] res_q [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit = wr_en_i && !stopped_i && (wr_ch_i == CH_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n)   res_q[g] <= '0;
            else if (hit) res_q[g] <= wr_res_i;
        end

        assign regs_o[g] = {res_q[g], {PAD_W{1'b0}}};

        p_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && !stopped_i && wr_ch_i == CH_W'(g))
            |=> regs_o[g][REG_W-1:PAD_W] == $past(wr_res_i));
        p_other_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en_i && wr_ch_i == CH_W'(g)) |=> $stable(regs_o[g]));
        p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            stopped_i |=> $stable(regs_o[g]));
    end
endmodule

// File: rtl/adcres_read_port.sv
module adcres_read_port #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned REG_W  = 16,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned PAD_W  = 6,
    localparam int unsigned CH_W   = $clog2(NUM_CH),
    localparam int unsigned ADDR_W = CH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stopped_i,
    input  logic [REG_W-1:0]  regs_i [NUM_CH],
    input  logic              rd_en_i,
    input  logic              rd_word_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [REG_W-1:0]  rd_data_o
);
    logic [CH_W-1:0]   sel_ch;
    logic              lo_sel;
    logic [REG_W-1:0]  sel_reg;
    logic              load_tmp;
    logic [BYTE_W-1:0] tmp_q;

    assign sel_ch   = rd_addr_i[ADDR_W-1:1];
    assign lo_sel   = rd_addr_i[0];
    assign sel_reg  = regs_i[sel_ch];
    assign load_tmp = rd_en_i && !stopped_i && (rd_word_i || !lo_sel);

    always_ff @(posedge clk) begin
        if (!rst_n)        tmp_q <= '0;
        else if (load_tmp) tmp_q <= sel_reg[BYTE_W-1:0];
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_en_i && !stopped_i) begin
            if (rd_word_i)    rd_data_o = sel_reg;
            else if (!lo_sel) rd_data_o[BYTE_W-1:0] = sel_reg[REG_W-1 -: BYTE_W];
            else              rd_data_o[BYTE_W-1:0] = tmp_q;
        end
    end

    p_tmp_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !stopped_i && !rd_word_i && !rd_addr_i[0])
        |=> tmp_q == $past(regs_i[rd_addr_i[ADDR_W-1:1]][BYTE_W-1:0]));
    p_tmp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_i && (rd_word_i || !rd_addr_i[0])) |=> $stable(tmp_q));
    p_word_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_word_i) |-> rd_data_o[PAD_W-1:0] == '0);
    p_stop_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stopped_i |-> rd_data_o == '0);
    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |-> rd_data_o == '0);
endmodule

// File: rtl/adcres_regs.sv
module adcres_regs #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned RES_W  = 10,
    parameter int unsigned REG_W  = 16,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned CH_W   = $clog2(NUM_CH),
    localparam int unsigned ADDR_W = CH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_i,
    input  logic              cnv_we_i,
    input  logic [CH_W-1:0]   cnv_ch_i,
    input  logic [RES_W-1:0]  cnv_res_i,
    input  logic              rd_en_i,
    input  logic              rd_word_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [REG_W-1:0]  rd_data_o
);
    logic             stopped;
    logic [REG_W-1:0] regs_w [NUM_CH];

    adcres_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_req_i (stop_i),
        .stopped_o  (stopped)
    );

    adcres_bank #(
        .NUM_CH (NUM_CH),
        .RES_W  (RES_W),
        .REG_W  (REG_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .stopped_i (stopped),
        .wr_en_i   (cnv_we_i),
        .wr_ch_i   (cnv_ch_i),
        .wr_res_i  (cnv_res_i),
        .regs_o    (regs_w)
    );

    adcres_read_port #(
        .NUM_CH (NUM_CH),
        .REG_W  (REG_W),
        .BYTE_W (BYTE_W),
        .PAD_W  (REG_W - RES_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .stopped_i (stopped),
        .regs_i    (regs_w),
        .rd_en_i   (rd_en_i),
        .rd_word_i (rd_word_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );
endmodule

// File: tb/adcres_regs_tb.sv
module adcres_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stop_i = 1'b0;
    logic        cnv_we_i = 1'b0;
    logic [1:0]  cnv_ch_i = '0;
    logic [9:0]  cnv_res_i = '0;
    logic        rd_en_i = 1'b0;
    logic        rd_word_i = 1'b0;
    logic [2:0]  rd_addr_i = '0;
    logic [15:0] rd_data_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    logic [15:0] m_reg [4];
    logic [7:0]  m_tmp;
    logic        m_stop;

    always #10 clk = ~clk;

    adcres_regs u_dut (
        .clk(clk), .rst_n(rst_n), .stop_i(stop_i),
        .cnv_we_i(cnv_we_i), .cnv_ch_i(cnv_ch_i), .cnv_res_i(cnv_res_i),
        .rd_en_i(rd_en_i), .rd_word_i(rd_word_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o)
    );

    function automatic logic [15:0] exp_read(logic rd, logic wd, logic [2:0] a);
        if (!rd || m_stop) return 16'h0000;
        if (wd)            return m_reg[a[2:1]];
        if (!a[0])         return {8'h00, m_reg[a[2:1]][15:8]};
        return {8'h00, m_tmp};
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(string tag, logic we, logic [1:0] ch, logic [9:0] d,
                       logic rd, logic wd, logic [2:0] a, logic stp);
        @(negedge clk);
        cnv_we_i = we; cnv_ch_i = ch; cnv_res_i = d;
        rd_en_i = rd; rd_word_i = wd; rd_addr_i = a; stop_i = stp;
        #1;
        check(tag, rd_data_o, exp_read(rd, wd, a));
        @(posedge clk);
        if (!m_stop) begin
            if (rd && (wd || !a[0])) m_tmp = m_reg[a[2:1]][7:0];
            if (we) m_reg[ch] = {d, 6'b0};
        end
        m_stop = stp;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 4; i++) m_reg[i] = '0;
        m_tmp = '0; m_stop = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R8: reset state
        for (int c = 0; c < 4; c++) cyc("R8 reset word", 0, 0, 0, 1, 1, 3'(c*2), 0);
        // R10: low read with no prior high read returns holding byte
        cyc("R10 low no high", 0, 0, 0, 1, 0, 3'd5, 0);
        // R1: load all channels
        cyc("R1 write", 1, 0, 10'h3FF, 0, 0, 0, 0);
        cyc("R1 write", 1, 1, 10'h155, 0, 0, 0, 0);
        cyc("R1 write", 1, 2, 10'h2AA, 0, 0, 0, 0);
        cyc("R1 write", 1, 3, 10'h001, 0, 0, 0, 0);
        // R2 R6: word reads
        for (int c = 0; c < 4; c++) cyc("R6 R2 word", 0, 0, 0, 1, 1, 3'(c*2+1), 0);
        check("R2 pad", {10'h0, rd_data_o[5:0]}, 16'h0);
        // R3 R4: high then low, low through another channel address
        cyc("R3 high", 0, 0, 0, 1, 0, 3'd2, 0);
        cyc("R4 low", 0, 0, 0, 1, 0, 3'd3, 0);
        cyc("R4 low other ch", 0, 0, 0, 1, 0, 3'd7, 0);
        // R5: converter update between the two byte reads
        cyc("R5 high", 0, 0, 0, 1, 0, 3'd4, 0);
        cyc("R5 update", 1, 2, 10'h0C3, 0, 0, 0, 0);
        cyc("R5 low", 0, 0, 0, 1, 0, 3'd5, 0);
        check("R5 low old", rd_data_o, 16'h0080);
        // R9: same-cycle write and high read
        cyc("R9 collide", 1, 0, 10'h102, 1, 0, 3'd0, 0);
        check("R9 old high", rd_data_o, 16'h00FF);
        cyc("R9 low", 0, 0, 0, 1, 0, 3'd1, 0);
        cyc("R9 new high", 0, 0, 0, 1, 0, 3'd0, 0);
        check("R9 new high", rd_data_o, 16'h0040);
        // R10: word read refreshes holding byte, then stray low read
        cyc("R6 word ch3", 0, 0, 0, 1, 1, 3'd6, 0);
        cyc("R10 stray low", 0, 0, 0, 1, 0, 3'd1, 0);
        // R11: idle
        cyc("R11 idle", 1, 3, 10'h3C0, 0, 0, 3'd6, 0);
        // R7: stop
        cyc("R7 req stop", 0, 0, 0, 1, 0, 3'd2, 1);
        cyc("R7 stop write", 1, 1, 10'h0F0, 1, 1, 3'd2, 1);
        cyc("R7 stop high", 0, 0, 0, 1, 0, 3'd6, 1);
        cyc("R7 release", 0, 0, 0, 1, 0, 3'd1, 0);
        cyc("R7 low kept", 0, 0, 0, 1, 0, 3'd1, 0);
        cyc("R7 word kept", 0, 0, 0, 1, 1, 3'd2, 0);
        check("R7 word kept", rd_data_o, 16'h5540);

        // R4 random traffic with same-channel collisions (R9)
        for (int i = 0; i < 600; i++) begin
            logic [1:0] ch;
            ch = 2'($urandom_range(0, 3));
            cyc("R4 random", 1'($urandom_range(0, 1)), ch, 10'($urandom),
                ($urandom_range(0, 7) != 0), ($urandom_range(0, 3) == 0),
                {($urandom_range(0, 1) != 0) ? ch : 2'($urandom), 1'($urandom)},
                ($urandom_range(0, 15) == 0));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule